// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

This block collects the interrupt requests of one group of peripheral sources into a latched status register. Each source may arrive as a single-cycle pulse or as a held level. A mask register gates the status into a read-only result. Software clears status bits by writing ones to them. It changes the mask only through two write-only-style ports: one that sets bits and one that clears bits. Because of this, two agents can never lose each other's mask changes in a read-modify-write race.

The masked result leaves the block in one of two shapes, chosen by a global mode input. In per-line mode, every result bit drives its own output wire toward the interrupt controller. In combined mode, the result bits are ORed onto a single group wire and the per-line wires stay low. Both shapes come from a register, so they trail the result by one clock. Registers are selected by a small word address on a plain read/write port. Reads are combinational and writes take effect at the clock edge.

Top module: `irqgrp_top`

## Requirements
- R1: After synchronous reset, the status and mask registers are zero, every output interrupt line is low and the group line is low.
- R2: Word addresses select the registers as follows: 0 is status, 1 is mask-set, 2 is mask-clear, 3 is result, and 4 is reserved. Addresses 5 to 7 behave like the reserved location.
- R3: In any clock cycle where a source input bit is high, the matching status bit becomes set at that edge. It then stays set until it is cleared.
- R4: A write to address 0 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R5: A write to address 1 sets the mask bits where the data is 1. A write to address 2 clears the mask bits where the data is 1. Zero data bits leave the mask unchanged in both cases.
- R6: Reading address 1 and reading address 2 both return the current mask register.
- R7: Reading address 3 returns status AND mask. Writing address 3 changes neither status nor mask.
- R8: When the mode input is 1, each per-line output equals the corresponding result bit one clock earlier, and the group line is low.
- R9: When the mode input is 0, every per-line output is low, and the group line equals the OR of the result bits one clock earlier.
- R10: If a source event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R11: Reserved addresses read as zero, and writes to them change neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Source interrupt requests (pulse or level) |
| direct_mode_i | input | 1 | 1 = per-line outputs, 0 = single ORed group output |
| bus_addr_i | input | 3 | Register word address |
| bus_we_i | input | 1 | Write strobe for the current address |
| bus_wdata_i | input | NUM_SRC | Write data |
| bus_rdata_o | output | NUM_SRC | Read data for the current address (combinational) |
| line_irq_o | output | NUM_SRC | Registered per-line interrupt outputs |
| group_irq_o | output | 1 | Registered combined group interrupt |

## Verification
The bench builds the block with NUM_SRC set to 8. This makes every possible source pattern reachable: all 256 of them are pulsed in turn. Each pattern is paired with a derived mask, with a partial write-1-to-clear and with a partial mask clear. The expected status, result, mask and routed outputs are computed arithmetically from the pattern, in both output modes. Directed cases then add the event-versus-clear collision, writes to the read-only and reserved locations, and the reset state of every address.

// File: rtl/irqgrp_pkg.sv
package irqgrp_pkg;

    localparam int ADDR_W = 3;

    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t ADR_STATUS = 3'd0;
    localparam reg_addr_t ADR_EN_SET = 3'd1;
    localparam reg_addr_t ADR_EN_CLR = 3'd2;
    localparam reg_addr_t ADR_RESULT = 3'd3;
    localparam reg_addr_t ADR_RSVD   = 3'd4;

    typedef enum logic [2:0] {
        SEL_STATUS,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_RESULT,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic st_clr;
        logic en_set;
        logic en_clr;
    } wr_strobe_t;

    function automatic reg_sel_e decode_sel(reg_addr_t a);
        case (a)
            ADR_STATUS: return SEL_STATUS;
            ADR_EN_SET: return SEL_EN_SET;
            ADR_EN_CLR: return SEL_EN_CLR;
            ADR_RESULT: return SEL_RESULT;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic wr_strobe_t make_strobes(reg_sel_e sel, logic we);
        wr_strobe_t s;
        s.st_clr = we && (sel == SEL_STATUS);
        s.en_set = we && (sel == SEL_EN_SET);
        s.en_clr = we && (sel == SEL_EN_CLR);
        return s;
    endfunction

endpackage

// File: rtl/irqgrp_regdec.sv
module irqgrp_regdec
    import irqgrp_pkg::*;
(
    input  reg_addr_t  addr_i,
    input  logic       we_i,
    output reg_sel_e   sel_o,
    output wr_strobe_t strobe_o
);

    always_comb begin
        sel_o    = decode_sel(addr_i);
        strobe_o = make_strobes(sel_o, we_i);
    end

endmodule

// File: rtl/irqgrp_bits.sv
module irqgrp_bits
    import irqgrp_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  wr_strobe_t         strobe_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] enable_o
);

    logic [NUM_SRC-1:0] status_q, status_d;
    logic [NUM_SRC-1:0] enable_q, enable_d;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        // a fresh event outranks a clear in the same cycle
        assign status_d[i] = src_i[i]
                           | (status_q[i] & ~(strobe_i.st_clr & wdata_i[i]));
        assign enable_d[i] = (strobe_i.en_set & wdata_i[i])
                           | (enable_q[i] & ~(strobe_i.en_clr & wdata_i[i]));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;

endmodule

// File: rtl/irqgrp_route.sv
module irqgrp_route #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               direct_i,
    input  logic [NUM_SRC-1:0] result_i,
    output logic [NUM_SRC-1:0] line_o,
    output logic               group_o
);

    logic [NUM_SRC-1:0] line_d;
    logic               group_d;

    always_comb begin
        line_d  = direct_i ? result_i : '0;
        group_d = ~direct_i & (|result_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            line_o  <= '0;
            group_o <= 1'b0;
        end else begin
            line_o  <= line_d;
            group_o <= group_d;
        end
    end

endmodule

// File: rtl/irqgrp_top.sv
module irqgrp_top
    import irqgrp_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                direct_mode_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic                bus_we_i,
    input  logic [NUM_SRC-1:0]  bus_wdata_i,
    output logic [NUM_SRC-1:0]  bus_rdata_o,
    output logic [NUM_SRC-1:0]  line_irq_o,
    output logic                group_irq_o
);

    reg_sel_e           sel;
    wr_strobe_t         strobe;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] result;

    irqgrp_regdec u_dec (
        .addr_i   (bus_addr_i),
        .we_i     (bus_we_i),
        .sel_o    (sel),
        .strobe_o (strobe)
    );

    irqgrp_bits #(.NUM_SRC(NUM_SRC)) u_bits (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .src_i    (src_i),
        .wdata_i  (bus_wdata_i),
        .strobe_i (strobe),
        .status_o (status_q),
        .enable_o (enable_q)
    );

    assign result = status_q & enable_q;

    irqgrp_route #(.NUM_SRC(NUM_SRC)) u_route (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .direct_i (direct_mode_i),
        .result_i (result),
        .line_o   (line_irq_o),
        .group_o  (group_irq_o)
    );

    always_comb begin
        case (sel)
            SEL_STATUS: bus_rdata_o = status_q;
            SEL_EN_SET,
            SEL_EN_CLR: bus_rdata_o = enable_q;
            SEL_RESULT: bus_rdata_o = result;
            default:    bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irqgrp_chk.sv
module irqgrp_chk
    import irqgrp_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic [NUM_SRC-1:0] src_i,
    input logic               direct_mode_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic               bus_we_i,
    input logic [NUM_SRC-1:0] bus_wdata_i,
    input logic [NUM_SRC-1:0] bus_rdata_o,
    input logic [NUM_SRC-1:0] line_irq_o,
    input logic               group_irq_o,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q
);

    // R3
    status_rise_needs_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((status_q & ~$past(status_q)) & ~$past(src_i)) == '0);

    // R10
    event_sets_status_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (src_i != '0) |=> ((status_q & $past(src_i)) == $past(src_i)));

    // R4
    w1c_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_we_i && bus_addr_i == ADR_STATUS)
        |=> ((status_q & $past(bus_wdata_i & ~src_i)) == '0));

    // R5
    mask_holds_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(bus_we_i && (bus_addr_i == ADR_EN_SET || bus_addr_i == ADR_EN_CLR))
        |=> $stable(enable_q));

    // R8
    direct_route_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        direct_mode_i |=> (line_irq_o == $past(status_q & enable_q)) && !group_irq_o);

    // R9
    group_route_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !direct_mode_i |=> (line_irq_o == '0)
                           && (group_irq_o == |$past(status_q & enable_q)));

    // R11
    rsvd_reads_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_addr_i >= ADR_RSVD) |-> (bus_rdata_o == '0));

endmodule

bind irqgrp_top irqgrp_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .src_i         (src_i),
    .direct_mode_i (direct_mode_i),
    .bus_addr_i    (bus_addr_i),
    .bus_we_i      (bus_we_i),
    .bus_wdata_i   (bus_wdata_i),
    .bus_rdata_o   (bus_rdata_o),
    .line_irq_o    (line_irq_o),
    .group_irq_o   (group_irq_o),
    .status_q      (status_q),
    .enable_q      (enable_q)
);

// File: tb/irqgrp_tb_top.sv
module irqgrp_tb_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src = '0;
    logic         direct = 1'b0;
    logic [2:0]   addr = '0;
    logic         we = 1'b0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic [N-1:0] line;
    logic         group;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irqgrp_top #(.NUM_SRC(N)) dut_i (
        .clk_i         (clk),
        .rst_i         (rst),
        .src_i         (src),
        .direct_mode_i (direct),
        .bus_addr_i    (addr),
        .bus_we_i      (we),
        .bus_wdata_i   (wdata),
        .bus_rdata_o   (rdata),
        .line_irq_o    (line),
        .group_irq_o   (group)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic pulse(input logic [N-1:0] v);
        @(negedge clk);
        src = v;
        @(negedge clk);
        src = '0;
    endtask

    logic [N-1:0] r;
    logic [N-1:0] e, w, c, exp_res;
    logic         finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at every address and on outputs
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], r);
            check("R1 reset read", r, '0);
        end
        check("R1 reset lines", line, '0);
        check("R1 reset group", {{(N-1){1'b0}}, group}, '0);

        // Sweep every source pattern
        for (int v = 0; v < 256; v++) begin
            wr(3'd2, '1);
            wr(3'd0, '1);
            pulse(v[N-1:0]);
            e = v[N-1:0] ^ 8'h5A ^ {v[0], v[7:1]};
            wr(3'd1, e);
            direct = v[0];
            @(negedge clk);
            exp_res = v[N-1:0] & e;
            rd(3'd0, r); check("R3 status latch", r, v[N-1:0]);
            rd(3'd3, r); check("R7 result", r, exp_res);
            rd(3'd2, r); check("R6 mask via clr addr", r, e);
            rd(3'd1, r); check("R6 mask via set addr", r, e);
            if (direct) begin
                check("R8 lines", line, exp_res);
                check("R8 group low", {{(N-1){1'b0}}, group}, '0);
            end else begin
                check("R9 lines low", line, '0);
                check("R9 group", {{(N-1){1'b0}}, group}, {{(N-1){1'b0}}, |exp_res});
            end
            w = v[N-1:0] & 8'h33 | 8'h40;
            wr(3'd0, w);
            rd(3'd0, r); check("R4 w1c", r, v[N-1:0] & ~w);
            c = 8'h0F;
            wr(3'd2, c);
            rd(3'd1, r); check("R5 mask clear", r, e & ~c);
            wr(3'd1, 8'h10);
            rd(3'd1, r); check("R5 mask set", r, (e & ~c) | 8'h10);
        end

        // R10: event and clear collide on bit 2; bit 3 clears normally
        direct = 1'b0;
        wr(3'd0, '1);
        pulse(8'h08);
        @(negedge clk);
        addr = 3'd0; wdata = 8'h0C; we = 1'b1; src = 8'h04;
        @(negedge clk);
        we = 1'b0; src = '0; wdata = '0;
        rd(3'd0, r); check("R10 event wins", r, 8'h04);

        // R11 / R2: reserved addresses read zero and ignore writes
        wr(3'd1, 8'hF0);
        pulse(8'hA5);
        for (int a = 4; a < 8; a++) begin
            wr(a[2:0], '1);
            rd(a[2:0], r); check("R11 reserved zero", r, '0);
            rd(3'd0, r); check("R11 status kept", r, 8'hA5);
            rd(3'd1, r); check("R11 mask kept", r, 8'hF0);
        end

        // R7: result address is read-only
        wr(3'd3, 8'h00);
        wr(3'd3, 8'hFF);
        rd(3'd0, r); check("R7 status kept", r, 8'hA5);
        rd(3'd2, r); check("R7 mask kept", r, 8'hF0);
        rd(3'd3, r); check("R7 result", r, 8'hA0);

        // R2: decoded map: status at 0 differs from mask at 1
        rd(3'd0, r); check("R2 map status", r, 8'hA5);
        rd(3'd1, r); check("R2 map mask", r, 8'hF0);

        // R1: reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(3'd0, r); check("R1 status after reset", r, '0);
        rd(3'd1, r); check("R1 mask after reset", r, '0);
        check("R1 lines after reset", line, '0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule